// File: doc/BRIEF.md
# Three-Wire Configuration Bus Receiver

This block takes configuration words from a three-wire serial bus: a bit clock, a data line and an active-low frame select. While the frame select is low, each rising edge of the bit clock shifts one data bit into a shift register, most significant bit first. When the frame select returns high, the frame ends. The last bit shifted in is an address bit. It picks one of two holding words, and the bits shifted in before it are copied into that word. The holding words drive parallel field outputs. These fields configure dividers, phases, enables, current gains, a pretune level, a demodulator trim and a test-output selector.

The three bus lines are asynchronous to the block. They are resynchronised into the system clock, and their edges are detected there. The sender may clock in more bits than a frame needs. Only the most recent bits are kept, and nothing counts the pulses.

A power-down input works together with a retention input. While power-down is asserted and retention is low, both words are cleared and kept at zero. While power-down is asserted and retention is high, both words keep their contents.

Top module: `wcfg_rx`

## Requirements
- R1: After reset, every field output is zero.
- R2: Bit-clock rising edges that occur while the frame select is high capture nothing. A later frame containing no clock pulses reloads the shift contents that the last real frame left.
- R3: The field outputs change only on the low-to-high transition of the frame select. While bits are being shifted, the outputs hold their previous values.
- R4: A final bit of 1 loads word A from the 23 bits shifted in just before it, D22 first. The fields, from D22 down to D0, are: ref divider select D22:D21, swallow count D20:D16, main divider select D15:D14, filter phase D13, compensation phase D12, charge-pump polarity D11, filter enable D10, compensation enable D9, filter current D8:D6, pretune D5:D3 and charge-pump current D2:D0. Word B does not change.
- R5: A final bit of 0 loads word B from the 11 bits shifted in just before it, E10 first. The fields are demodulator trim E10:E6, compensation current E5:E3 and test select E2:E0. Word A does not change.
- R6: Extra leading bits in a frame are discarded. Only the last 24 bits captured are used, and the number of pulses is never checked.
- R7: While power-down is high and retention is low, both words are zero from the next clock cycle. Frames that end during this time are ignored.
- R8: While power-down is high and retention is high, both words keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sclk | input | 1 | Serial bit clock (asynchronous) |
| bus_sdat | input | 1 | Serial data (asynchronous) |
| bus_sel_n | input | 1 | Active-low frame select (asynchronous) |
| pwr_dn | input | 1 | Power-down request |
| keep_cfg | input | 1 | Keep the words during power-down |
| o_ref_sel | output | 2 | Reference divider select (D22:D21) |
| o_swallow | output | 5 | Swallow count (D20:D16) |
| o_main_sel | output | 2 | Main divider select (D15:D14) |
| o_filt_phase | output | 1 | Filter output phase (D13) |
| o_comp_phase | output | 1 | Compensation output phase (D12) |
| o_cp_pol | output | 1 | Charge-pump polarity (D11) |
| o_filt_en | output | 1 | Filter enable (D10) |
| o_comp_en | output | 1 | Compensation enable (D9) |
| o_filt_cur | output | 3 | Filter current gain (D8:D6) |
| o_pretune | output | 3 | Oscillator pretune (D5:D3) |
| o_cp_cur | output | 3 | Charge-pump current gain (D2:D0) |
| o_demod_trim | output | 5 | Demodulator trim (E10:E6) |
| o_comp_cur | output | 3 | Compensation current gain (E5:E3) |
| o_test_sel | output | 3 | Test-output select (E2:E0) |

## Verification
On every cycle, the assertions check three things:
- A word changes only when a load strobe or a clear is active.
- The two load strobes are never active together.
- Power-down without retention zeroes both words, and power-down with retention keeps them.

Some behaviour can only be shown by the bench's scenarios, which compare the fields against the bit positions in the requirements. These are the most-significant-first bit order, the address decoding, the discarding of surplus leading bits, and the fact that clock pulses outside a frame are ignored.

// File: rtl/wcfg_pkg.sv
package wcfg_pkg;
  localparam int WA_W = 23;
  localparam int WB_W = 11;

  typedef struct packed {
    logic [1:0] ref_sel;
    logic [4:0] swallow;
    logic [1:0] main_sel;
    logic       filt_phase;
    logic       comp_phase;
    logic       cp_pol;
    logic       filt_en;
    logic       comp_en;
    logic [2:0] filt_cur;
    logic [2:0] pretune;
    logic [2:0] cp_cur;
  } word_a_t;

  typedef struct packed {
    logic [4:0] demod_trim;
    logic [2:0] comp_cur;
    logic [2:0] test_sel;
  } word_b_t;
endpackage

// File: rtl/wcfg_sync.sv
module wcfg_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  localparam int CW = N * STAGES;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    chain_d[N-1:0] = din;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s*N +: N] = chain_q[(s-1)*N +: N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[CW-1 -: N];
endmodule

// File: rtl/wcfg_shifter.sv
module wcfg_shifter #(
  parameter int SHIFT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               sel_n_s,
  output logic [SHIFT_W-1:0] shift_q,
  output logic               frame_end
);
  logic               sclk_d;
  logic               sel_d;
  logic [SHIFT_W-1:0] shift_d;
  logic               sclk_rise;
  logic               shift_en;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign shift_en  = sclk_rise & ~sel_n_s;
  assign frame_end = sel_n_s & ~sel_d;

  always_comb begin
    shift_d = shift_q;
    if (shift_en) shift_d = {shift_q[SHIFT_W-2:0], sdat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sel_d   <= 1'b1;
      shift_q <= '0;
    end else begin
      sclk_d  <= sclk_s;
      sel_d   <= sel_n_s;
      shift_q <= shift_d;
    end
  end
endmodule

// File: rtl/wcfg_latch.sv
module wcfg_latch
  import wcfg_pkg::*;
#(
  parameter int SHIFT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] shift_q,
  input  logic               frame_end,
  input  logic               clr,
  output word_a_t            word_a,
  output word_b_t            word_b,
  output logic               ld_a,
  output logic               ld_b
);
  word_a_t word_a_d;
  word_b_t word_b_d;

  assign ld_a = frame_end & ~clr &  shift_q[0];
  assign ld_b = frame_end & ~clr & ~shift_q[0];

  always_comb begin
    word_a_d = word_a;
    word_b_d = word_b;
    if (clr) begin
      word_a_d = '0;
      word_b_d = '0;
    end else begin
      if (ld_a) word_a_d = word_a_t'(shift_q[WA_W:1]);
      if (ld_b) word_b_d = word_b_t'(shift_q[WB_W:1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= '0;
      word_b <= '0;
    end else begin
      word_a <= word_a_d;
      word_b <= word_b_d;
    end
  end
endmodule

// File: rtl/wcfg_rx.sv
module wcfg_rx
  import wcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sclk,
  input  logic       bus_sdat,
  input  logic       bus_sel_n,
  input  logic       pwr_dn,
  input  logic       keep_cfg,
  output logic [1:0] o_ref_sel,
  output logic [4:0] o_swallow,
  output logic [1:0] o_main_sel,
  output logic       o_filt_phase,
  output logic       o_comp_phase,
  output logic       o_cp_pol,
  output logic       o_filt_en,
  output logic       o_comp_en,
  output logic [2:0] o_filt_cur,
  output logic [2:0] o_pretune,
  output logic [2:0] o_cp_cur,
  output logic [4:0] o_demod_trim,
  output logic [2:0] o_comp_cur,
  output logic [2:0] o_test_sel
);
  localparam int SHIFT_W = ((WA_W > WB_W) ? WA_W : WB_W) + 1;

  logic [2:0]         bus_s;
  logic [SHIFT_W-1:0] shift_q;
  logic               frame_end;
  logic               clr_cfg;
  logic               ld_a;
  logic               ld_b;
  word_a_t            word_a_q;
  word_b_t            word_b_q;

  assign clr_cfg = pwr_dn & ~keep_cfg;

  wcfg_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bus_sel_n, bus_sdat, bus_sclk}),
    .dout (bus_s)
  );

  wcfg_shifter #(.SHIFT_W(SHIFT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (bus_s[0]),
    .sdat_s   (bus_s[1]),
    .sel_n_s  (bus_s[2]),
    .shift_q  (shift_q),
    .frame_end(frame_end)
  );

  wcfg_latch #(.SHIFT_W(SHIFT_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_q  (shift_q),
    .frame_end(frame_end),
    .clr      (clr_cfg),
    .word_a   (word_a_q),
    .word_b   (word_b_q),
    .ld_a     (ld_a),
    .ld_b     (ld_b)
  );

  assign o_ref_sel    = word_a_q.ref_sel;
  assign o_swallow    = word_a_q.swallow;
  assign o_main_sel   = word_a_q.main_sel;
  assign o_filt_phase = word_a_q.filt_phase;
  assign o_comp_phase = word_a_q.comp_phase;
  assign o_cp_pol     = word_a_q.cp_pol;
  assign o_filt_en    = word_a_q.filt_en;
  assign o_comp_en    = word_a_q.comp_en;
  assign o_filt_cur   = word_a_q.filt_cur;
  assign o_pretune    = word_a_q.pretune;
  assign o_cp_cur     = word_a_q.cp_cur;
  assign o_demod_trim = word_b_q.demod_trim;
  assign o_comp_cur   = word_b_q.comp_cur;
  assign o_test_sel   = word_b_q.test_sel;
endmodule

// File: rtl/wcfg_rx_chk.sv
module wcfg_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_a,
  input logic        ld_b,
  input logic        pwr_dn,
  input logic        keep_cfg,
  input logic [22:0] word_a,
  input logic [10:0] word_b
);
  assert_wa_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_a && !pwr_dn) |=> $stable(word_a));

  assert_wb_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_b && !pwr_dn) |=> $stable(word_b));

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_a, ld_b}));

  assert_pd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !keep_cfg) |=> (word_a == '0 && word_b == '0));

  assert_pd_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !keep_cfg) |-> (!ld_a && !ld_b));

  assert_pd_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && keep_cfg && !ld_a && !ld_b) |=> ($stable(word_a) && $stable(word_b)));
endmodule

bind wcfg_rx wcfg_rx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ld_a    (ld_a),
  .ld_b    (ld_b),
  .pwr_dn  (pwr_dn),
  .keep_cfg(keep_cfg),
  .word_a  (word_a_q),
  .word_b  (word_b_q)
);

// File: tb/wcfg_rx_bench.sv
module wcfg_rx_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_sclk, bus_sdat, bus_sel_n, pwr_dn, keep_cfg;
  logic [1:0] o_ref_sel, o_main_sel;
  logic [4:0] o_swallow, o_demod_trim;
  logic o_filt_phase, o_comp_phase, o_cp_pol, o_filt_en, o_comp_en;
  logic [2:0] o_filt_cur, o_pretune, o_cp_cur, o_comp_cur, o_test_sel;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wcfg_rx u_wcfg_rx (
    .clk(clk), .rst_n(rst_n), .bus_sclk(bus_sclk), .bus_sdat(bus_sdat),
    .bus_sel_n(bus_sel_n), .pwr_dn(pwr_dn), .keep_cfg(keep_cfg),
    .o_ref_sel(o_ref_sel), .o_swallow(o_swallow), .o_main_sel(o_main_sel),
    .o_filt_phase(o_filt_phase), .o_comp_phase(o_comp_phase), .o_cp_pol(o_cp_pol),
    .o_filt_en(o_filt_en), .o_comp_en(o_comp_en), .o_filt_cur(o_filt_cur),
    .o_pretune(o_pretune), .o_cp_cur(o_cp_cur), .o_demod_trim(o_demod_trim),
    .o_comp_cur(o_comp_cur), .o_test_sel(o_test_sel)
  );

  function automatic logic [22:0] rd_a();
    return {o_ref_sel, o_swallow, o_main_sel, o_filt_phase, o_comp_phase, o_cp_pol,
            o_filt_en, o_comp_en, o_filt_cur, o_pretune, o_cp_cur};
  endfunction

  function automatic logic [10:0] rd_b();
    return {o_demod_trim, o_comp_cur, o_test_sel};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n);
    bus_sel_n = 1'b0;
    wait_clk(6);
    for (int i = n - 1; i >= 0; i--) begin
      bus_sdat = v[i];
      wait_clk(3);
      bus_sclk = 1'b1;
      wait_clk(6);
      bus_sclk = 1'b0;
      wait_clk(3);
    end
  endtask

  task automatic end_frame();
    bus_sel_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic send(input logic [63:0] v, input int n);
    shift_bits(v, n);
    end_frame();
  endtask

  task automatic t_reset();
    chk("R1 word A after reset", 32'(rd_a()), 32'h0);
    chk("R1 word B after reset", 32'(rd_b()), 32'h0);
  endtask

  task automatic t_word_a();
    logic [22:0] a = 23'h5A3C71;
    send({40'h0, a, 1'b1}, 24);
    chk("R4 ref_sel D22:D21", 32'(o_ref_sel), 32'(a[22:21]));
    chk("R4 swallow D20:D16", 32'(o_swallow), 32'(a[20:16]));
    chk("R4 main_sel D15:D14", 32'(o_main_sel), 32'(a[15:14]));
    chk("R4 phases D13:D11", 32'({o_filt_phase, o_comp_phase, o_cp_pol}), 32'(a[13:11]));
    chk("R4 enables D10:D9", 32'({o_filt_en, o_comp_en}), 32'(a[10:9]));
    chk("R4 filt_cur D8:D6", 32'(o_filt_cur), 32'(a[8:6]));
    chk("R4 pretune D5:D3", 32'(o_pretune), 32'(a[5:3]));
    chk("R4 cp_cur D2:D0", 32'(o_cp_cur), 32'(a[2:0]));
    chk("R4 word B untouched", 32'(rd_b()), 32'h0);
  endtask

  task automatic t_word_b();
    logic [10:0] b = 11'h5B3;
    send({52'h0, b, 1'b0}, 12);
    chk("R5 demod_trim E10:E6", 32'(o_demod_trim), 32'(b[10:6]));
    chk("R5 comp_cur E5:E3", 32'(o_comp_cur), 32'(b[5:3]));
    chk("R5 test_sel E2:E0", 32'(o_test_sel), 32'(b[2:0]));
    chk("R5 word A untouched", 32'(rd_a()), 32'h5A3C71);
  endtask

  task automatic t_midframe();
    shift_bits({40'h0, 23'h123456, 1'b1}, 24);
    wait_clk(10);
    chk("R3 word A held during shifting", 32'(rd_a()), 32'h5A3C71);
    end_frame();
    chk("R3 word A loaded at frame end", 32'(rd_a()), 32'h123456);
  endtask

  task automatic t_idle_clocks();
    send({52'h0, 11'h2CA, 1'b0}, 12);
    bus_sdat = 1'b1;
    for (int i = 0; i < 30; i++) begin
      wait_clk(3); bus_sclk = 1'b1; wait_clk(6); bus_sclk = 1'b0; wait_clk(3);
    end
    send(64'h0, 0);
    chk("R2 word B reloaded from old bits", 32'(rd_b()), 32'h2CA);
    chk("R2 word A unchanged", 32'(rd_a()), 32'h123456);
  endtask

  task automatic t_surplus();
    send({34'h0, 6'b111111, 23'h2C5E19, 1'b1}, 30);
    chk("R6 word A after surplus bits", 32'(rd_a()), 32'h2C5E19);
    send({40'h0, 12'hFFF, 11'h2A7, 1'b0}, 24);
    chk("R6 word B after surplus bits", 32'(rd_b()), 32'h2A7);
    chk("R6 word A kept", 32'(rd_a()), 32'h2C5E19);
  endtask

  task automatic t_pd_keep();
    keep_cfg = 1'b1;
    pwr_dn = 1'b1;
    wait_clk(20);
    chk("R8 word A kept in power-down", 32'(rd_a()), 32'h2C5E19);
    chk("R8 word B kept in power-down", 32'(rd_b()), 32'h2A7);
    pwr_dn = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_pd_clear();
    keep_cfg = 1'b0;
    pwr_dn = 1'b1;
    wait_clk(2);
    chk("R7 word A cleared", 32'(rd_a()), 32'h0);
    chk("R7 word B cleared", 32'(rd_b()), 32'h0);
    send({40'h0, 23'h7FFFFF, 1'b1}, 24);
    chk("R7 frame ignored in power-down", 32'(rd_a()), 32'h0);
    pwr_dn = 1'b0;
    wait_clk(4);
    chk("R7 word A zero after wake", 32'(rd_a()), 32'h0);
    chk("R7 word B zero after wake", 32'(rd_b()), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_sclk = 1'b0;
    bus_sdat = 1'b0;
    bus_sel_n = 1'b1;
    pwr_dn = 1'b0;
    keep_cfg = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_word_a();
    t_word_b();
    t_midframe();
    t_idle_clocks();
    t_surplus();
    t_pd_keep();
    t_pd_clear();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule